// File: doc/BRIEF.md
# Timestamped Host-Write Capture FIFO

This block records every byte that a host writes to a debug or power-on progress port and holds the bytes in a queue until a local processor reads them. When stamping is on, each queued byte carries the value of a free-running 24-bit time counter taken in the cycle of the write. The counter advances on a single-cycle base-rate enable input, divided down by 1, 2, 4 or 8 as configured.

The local processor sees a small register bus. One register pops the oldest entry. One register holds the mode fields and two self-clearing commands, queue flush and counter clear. One register reports queue state. One register gives read and write access to the time counter. One register holds an enable that gates host capture. A level interrupt is raised while the queue holds at least a chosen number of entries. Host bus decoding and interrupt routing sit outside this block.

Top module: `hostcap_top`

## Requirements
- R1: While the enable bit (offset 0x330, bit 0) is set, a pulse on `host_wr` stores one entry. The entry is `host_byte` in bits [7:0] and, when stamping is on, the time counter of that cycle in bits [31:8]. The queue holds 16 entries.
- R2: A bus read of offset 0x100 returns the oldest entry and removes it. A read of that offset on an empty queue returns zero and leaves the queue order unchanged.
- R3: A host write to a full queue is dropped. It sets the overrun flag (status bit 1), which stays set until a flush. Reading status never clears it.
- R4: Status bit 0 (offset 0x108) is 1 exactly while the queue holds at least one entry. Status bits [31:2] read zero.
- R5: The mode register (offset 0x104) stores bits [7:3] and reads them back in place. Bits 2:0 and [31:8] read zero.
- R6: Writing the mode register with bit 1 set empties the queue and clears overrun.
- R7: The counter advances by one every 2^D base ticks, where D is mode bits [4:3] (0 to 3).
- R8: Offset 0x10C reads the counter in bits [31:8] with zero below. A write there loads bits [31:8] into the counter.
- R9: Writing the mode register with bit 2 set zeroes the counter and the tick divider phase.
- R10: When mode bit 5 (stamping on) is clear, bits [31:8] of a captured entry are zero.
- R11: `irq` is high while the occupancy is at or above the level picked by mode bits [7:6]: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14.
- R12: The enable register reads back bit 0 and resets to 0. While it is 0, host writes change neither the queue nor overrun.
- R13: After reset the queue is empty, overrun is clear, the counter is zero, the mode and enable registers are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_byte | input | 8 | Byte written by the host |
| tick_base | input | 1 | One-cycle base-rate time enable |
| bus_sel | input | 1 | Local bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Local bus byte offset |
| bus_wdata | input | 32 | Local bus write data |
| bus_rdata | output | 32 | Local bus read data, combinational for the selected offset |
| irq | output | 1 | Occupancy at or above threshold |

## Verification
Read data is combinational. The bench samples `bus_rdata` one time unit after it drives the address at a falling edge, and the pop or write takes effect at the following rising edge. Host writes, ticks, counter loads and mode commands all register on one rising edge, so their results appear in the next cycle. The bench checks status, counter and `irq` only after the half cycle that follows that edge. Stamp values are predicted by counting the ticks the bench issued and dividing by the selected ratio, not by watching the counter.

// File: rtl/hostcap_pkg.sv
package hostcap_pkg;

  localparam int DIV_W = 2;
  localparam int PHASE_W = (1 << DIV_W) - 1;

  typedef struct packed {
    logic [1:0] thr_code;
    logic       stamp_on;
    logic [1:0] div_code;
  } mode_t;

  // Occupancy level at which the interrupt asserts
  function automatic int unsigned thr_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Last divider phase before the counter advances (divide by 2^code)
  function automatic logic [PHASE_W-1:0] phase_last(input logic [1:0] code);
    case (code)
      2'd0:    return PHASE_W'(0);
      2'd1:    return PHASE_W'(1);
      2'd2:    return PHASE_W'(3);
      default: return PHASE_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/hostcap_fifo.sv
module hostcap_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             overrun
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok, drop_evt;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (32'(count) == DEPTH);
  assign empty    = (count == '0);
  assign push_ok  = push_req && !full;
  assign pop_ok   = pop_req && !empty;
  assign drop_evt = push_req && full;
  assign rd_data  = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (drop_evt) overrun <= 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req && !flush) |=> (full && overrun));
  assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> overrun);
  assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !flush) |=> $stable(rd_ptr));
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !overrun));

endmodule

// File: rtl/hostcap_timer.sv
module hostcap_timer
  import hostcap_pkg::*;
#(
  parameter int STAMP_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [DIV_W-1:0]   div_code,
  input  logic               clr,
  input  logic               load,
  input  logic [STAMP_W-1:0] load_val,
  output logic [STAMP_W-1:0] stamp
);

  logic [PHASE_W-1:0] phase;
  logic               step_evt;

  assign step_evt = tick && (phase >= phase_last(div_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      stamp <= '0;
    end else if (clr) begin
      phase <= '0;
      stamp <= '0;
    end else begin
      if (tick) phase <= step_evt ? '0 : phase + PHASE_W'(1);
      if (load)          stamp <= load_val;
      else if (step_evt) stamp <= stamp + STAMP_W'(1);
    end
  end

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stamp == '0));
  assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (stamp == $past(load_val)));
  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !tick) |=> $stable(stamp));

endmodule

// File: rtl/hostcap_top.sv
module hostcap_top
  import hostcap_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int STAMP_W = 24,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 12,
  localparam int ENTRY_W = BYTE_W + STAMP_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [BYTE_W-1:0]  host_byte,
  input  logic               tick_base,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [ENTRY_W-1:0] bus_wdata,
  output logic [ENTRY_W-1:0] bus_rdata,
  output logic               irq
);

  localparam logic [ADDR_W-1:0] OFS_POP    = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] OFS_MODE   = ADDR_W'('h104);
  localparam logic [ADDR_W-1:0] OFS_STATE  = ADDR_W'('h108);
  localparam logic [ADDR_W-1:0] OFS_CLOCK  = ADDR_W'('h10C);
  localparam logic [ADDR_W-1:0] OFS_ENABLE = ADDR_W'('h330);

  mode_t              mode_q;
  logic               enable_q;
  logic               mode_wr, clock_wr, enable_wr, pop_rd;
  logic               flush_cmd, clear_cmd, cap_req;
  logic [STAMP_W-1:0] stamp;
  logic [ENTRY_W-1:0] cap_entry, head_entry;
  logic [CNT_W-1:0]   occupancy;
  logic               q_full, q_empty, q_overrun;

  assign mode_wr   = bus_sel && bus_we && (bus_addr == OFS_MODE);
  assign clock_wr  = bus_sel && bus_we && (bus_addr == OFS_CLOCK);
  assign enable_wr = bus_sel && bus_we && (bus_addr == OFS_ENABLE);
  assign pop_rd    = bus_sel && !bus_we && (bus_addr == OFS_POP);
  assign flush_cmd = mode_wr && bus_wdata[1];
  assign clear_cmd = mode_wr && bus_wdata[2];
  assign cap_req   = host_wr && enable_q;
  assign cap_entry = {mode_q.stamp_on ? stamp : STAMP_W'(0), host_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      enable_q <= 1'b0;
    end else begin
      if (mode_wr)   mode_q   <= mode_t'(bus_wdata[7:3]);
      if (enable_wr) enable_q <= bus_wdata[0];
    end
  end

  hostcap_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_cmd),
    .push_req(cap_req), .wr_data(cap_entry),
    .pop_req(pop_rd), .rd_data(head_entry),
    .count(occupancy), .full(q_full), .empty(q_empty), .overrun(q_overrun)
  );

  hostcap_timer #(.STAMP_W(STAMP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_base), .div_code(mode_q.div_code),
    .clr(clear_cmd), .load(clock_wr), .load_val(bus_wdata[ENTRY_W-1:BYTE_W]),
    .stamp(stamp)
  );

  assign irq = 32'(occupancy) >= thr_level(mode_q.thr_code);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        OFS_POP:    bus_rdata = head_entry;
        OFS_MODE:   bus_rdata = ENTRY_W'({mode_q, 3'b000});
        OFS_STATE:  bus_rdata = ENTRY_W'({q_overrun, !q_empty});
        OFS_CLOCK:  bus_rdata = {stamp, BYTE_W'(0)};
        OFS_ENABLE: bus_rdata = ENTRY_W'(enable_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  logic unused_full;
  assign unused_full = q_full;

  assert_disabled_no_overrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_q && !q_overrun) |=> !q_overrun);
  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cap_req) || $past(mode_wr)));

endmodule

// File: tb/hostcap_top_test.sv
module hostcap_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  // byte in [15:8], base ticks issued before the write in [7:0]
  localparam logic [15:0] VECS [0:5] = '{
    16'h3100, 16'hA202, 16'h0001, 16'hFF03, 16'h5C00, 16'h7E02
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_wr = 0;
  logic [7:0]  host_byte = 0;
  logic        tick_base = 0;
  logic        bus_sel = 0;
  logic        bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostcap_top uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_byte(host_byte),
    .tick_base(tick_base), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic host_put(input logic [7:0] b);
    @(negedge clk);
    host_wr = 1; host_byte = b;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_base = 1;
      @(posedge clk); #1;
      tick_base = 0;
    end
  endtask

  task automatic irq_now(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [23:0] stamp_exp;
    logic [31:0] expq [0:5];

    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R13 reset state
    bus_read(12'h108, rd); chk("R13 status", rd, 0);
    bus_read(12'h104, rd); chk("R13 mode", rd, 0);
    bus_read(12'h10C, rd); chk("R13 counter", rd, 0);
    bus_read(12'h330, rd); chk("R13 enable", rd, 0);
    bus_read(12'h100, rd); chk("R13 pop empty", rd, 0);
    irq_now("R13 irq", 0);

    // R12 disabled host write ignored
    host_put(8'h11);
    bus_read(12'h108, rd); chk("R12 disabled write", rd, 0);
    bus_write(12'h330, 32'h1);
    bus_read(12'h330, rd); chk("R12 enable readback", rd, 1);

    // Vector table: R1 R7 stamped capture, R11 level 1
    bus_write(12'h104, 32'h24);
    stamp_exp = 0;
    for (int i = 0; i < 6; i++) begin
      ticks(int'(VECS[i][7:0]));
      stamp_exp = stamp_exp + 24'(VECS[i][7:0]);
      expq[i] = {stamp_exp, VECS[i][15:8]};
      host_put(VECS[i][15:8]);
    end
    irq_now("R11 level1 irq", 1);
    bus_write(12'h104, 32'hE0);
    irq_now("R11 level14 irq low", 0);
    for (int i = 0; i < 6; i++) begin
      bus_read(12'h100, rd); chk("R1 R2 stamped entry", rd, expq[i]);
    end
    bus_read(12'h108, rd); chk("R4 empty after drain", rd, 0);

    // R2 empty read leaves order intact
    bus_read(12'h100, rd); chk("R2 empty read zero", rd, 0);
    bus_write(12'h104, 32'h00);
    host_put(8'h5A);
    bus_read(12'h108, rd); chk("R4 not empty", rd, 1);
    bus_read(12'h100, rd); chk("R2 entry after empty read", rd, 32'h5A);

    // R11 level 4
    bus_write(12'h104, 32'h40);
    for (int i = 0; i < 3; i++) host_put(8'(i));
    irq_now("R11 level4 below", 0);
    host_put(8'h03);
    irq_now("R11 level4 reached", 1);
    bus_write(12'h104, 32'h42);
    bus_read(12'h108, rd); chk("R6 flush empties", rd, 0);
    irq_now("R11 flush drops irq", 0);

    // R3 full queue, R11 level 14
    bus_write(12'h104, 32'hC0);
    for (int i = 0; i < 13; i++) host_put(8'h10 + 8'(i));
    irq_now("R11 13 below 14", 0);
    host_put(8'h1D);
    irq_now("R11 14 reached", 1);
    host_put(8'h1E);
    host_put(8'h1F);
    bus_read(12'h108, rd); chk("R3 full no overrun", rd, 1);
    host_put(8'hEE);
    bus_read(12'h108, rd); chk("R3 overrun set", rd, 3);
    bus_read(12'h108, rd); chk("R3 status read keeps overrun", rd, 3);
    for (int i = 0; i < 16; i++) begin
      bus_read(12'h100, rd); chk("R3 R10 kept entries", rd, 32'h10 + 32'(i));
    end
    bus_read(12'h100, rd); chk("R3 dropped byte absent", rd, 0);
    bus_read(12'h108, rd); chk("R3 overrun sticky when empty", rd, 2);
    bus_write(12'h104, 32'h02);
    bus_read(12'h108, rd); chk("R6 flush clears overrun", rd, 0);

    // R12 disable again
    bus_write(12'h330, 32'h0);
    host_put(8'h99);
    bus_read(12'h108, rd); chk("R12 write while disabled", rd, 0);
    bus_write(12'h330, 32'h1);

    // R7 R9 divider ratios
    bus_write(12'h104, 32'h14);
    ticks(8);
    bus_read(12'h10C, rd); chk("R7 divide by 4", rd, 32'h200);
    bus_write(12'h104, 32'h1C);
    ticks(15);
    bus_read(12'h10C, rd); chk("R7 divide by 8", rd, 32'h100);
    bus_write(12'h104, 32'h0C);
    ticks(5);
    bus_read(12'h10C, rd); chk("R7 R9 divide by 2", rd, 32'h200);

    // R8 load, R10 stamp off
    bus_write(12'h10C, 32'hABCDEF55);
    bus_read(12'h10C, rd); chk("R8 load", rd, 32'hABCDEF00);
    bus_write(12'h104, 32'h00);
    ticks(1);
    bus_read(12'h10C, rd); chk("R8 count after load", rd, 32'hABCDF000);
    host_put(8'h77);
    bus_read(12'h100, rd); chk("R10 stamp off", rd, 32'h77);
    bus_write(12'h104, 32'h04);
    bus_read(12'h10C, rd); chk("R9 counter clear", rd, 0);

    // R5 mode readback
    bus_write(12'h104, 32'hFFFF_FFFF);
    bus_read(12'h104, rd); chk("R5 mode readback", rd, 32'hF8);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule